// File: doc/BRIEF.md
# Bit-Sliced Integer ALU

This block is a purely combinational arithmetic and logic unit for 32-bit operands. It is made from a chain of identical one-bit slices. Each slice holds a full adder, an AND gate, an OR gate, an optional inverter on each operand and a four-way output selector. The carry ripples from each slice into the next one. Every slice receives the same three control fields: invert A, invert B and a two-bit function select. The invert-B control also supplies the carry into the lowest slice, so subtraction needs no separate control line.

All supported operations come from combinations of those controls:

- AND, OR, NAND and NOR use the logic gates, with the operand inverters providing NAND and NOR through De Morgan's law.
- Add, subtract and A-plus-not-B use the adder.
- Signed set-less-than selects a per-slice "less" input. Only the lowest slice's input is live: it is fed from a sign signal that the top slice produces after correcting for overflow.

A zero flag reports an all-zero result, so subtracting two values and testing the flag gives an equality test for conditional branches. Carry out and signed overflow always reflect the adder, whatever function is selected.

Top module: `alu32_sliced`

## Requirements
- R1: With both inverts at 0 and function select 0, result equals `opnd_a & opnd_b`.
- R2: With both inverts at 0 and function select 1, result equals `opnd_a | opnd_b`.
- R3: With both inverts at 0 and function select 2, result equals `(opnd_a + opnd_b) mod 2^32`, and `carry_out` is bit 32 of the unsigned sum.
- R4: With `inv_b`=1, `inv_a`=0 and function select 2, result equals `opnd_a - opnd_b` mod 2^32, and `carry_out` is 1 exactly when `opnd_a >= opnd_b` as unsigned values.
- R5: With both inverts at 1 and function select 0, result equals `~(opnd_a | opnd_b)`.
- R6: With both inverts at 1 and function select 1, result equals `~(opnd_a & opnd_b)`.
- R7: With `inv_b`=1, `inv_a`=0 and function select 3, result bit 0 is 1 exactly when `opnd_a < opnd_b` as two's-complement values, and bits 31..1 are 0. This holds even when `opnd_a - opnd_b` overflows. For example, 10 against 11 gives 1.
- R8: `zero` is 1 exactly when all 32 result bits are 0. In subtract mode it is 1 exactly when `opnd_a == opnd_b`.
- R9: `overflow` is 1 exactly when the adder's signed result differs from the true signed sum of its inverted-or-plain operands plus carry-in. It equals the carry into bit 31 XOR the carry out of bit 31, for every function select.
- R10: The carry into bit 0 equals `inv_b`. With `inv_a`=1, `inv_b`=0 and function select 2, result equals `~opnd_a + opnd_b` mod 2^32.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand |
| inv_a | input | 1 | Invert first operand before the gates and the adder |
| inv_b | input | 1 | Invert second operand; also the carry into bit 0 |
| fn_sel | input | 2 | 0 AND, 1 OR, 2 adder sum, 3 less-than bit |
| result | output | 32 | Selected result |
| zero | output | 1 | All result bits are 0 |
| carry_out | output | 1 | Carry out of bit 31 |
| overflow | output | 1 | Signed overflow of the adder |

## Verification
The assertions only check their properties when every operand and control input carries a known 0 or 1. Each property is also tied to one specific control pattern, such as subtract mode for the equality and less-than checks. The stimulus therefore always drives fully defined values and revisits each control pattern many times. Random operands are mixed with directed ones: zero, all ones, the most negative value, the most positive value, and pairs that overflow in both add and subtract. Together these reach the sign-correction path of the less-than function and both values of every flag.

// File: rtl/alu_slice_pkg.sv
package alu_slice_pkg;

    localparam int unsigned SEL_W = 2;

    typedef enum logic [SEL_W-1:0] {
        SEL_AND  = 2'd0,
        SEL_OR   = 2'd1,
        SEL_SUM  = 2'd2,
        SEL_LESS = 2'd3
    } fn_sel_e;

    typedef struct packed {
        logic    flip_a;
        logic    flip_b;
        fn_sel_e sel;
    } slice_ctl_t;

    typedef struct packed {
        logic sum;
        logic cout;
    } fa_out_t;

    function automatic fa_out_t full_add(input logic x, input logic y, input logic c);
        fa_out_t r;
        r.sum  = x ^ y ^ c;
        r.cout = (x & y) | (x & c) | (y & c);
        return r;
    endfunction

    function automatic logic pick_out(input fn_sel_e s, input logic v_and,
                                      input logic v_or, input logic v_sum,
                                      input logic v_less);
        logic r;
        unique case (s)
            SEL_AND:  r = v_and;
            SEL_OR:   r = v_or;
            SEL_SUM:  r = v_sum;
            default:  r = v_less;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/alu_bit_slice.sv
module alu_bit_slice
    import alu_slice_pkg::*;
(
    input  logic       a_bit,
    input  logic       b_bit,
    input  slice_ctl_t ctl,
    input  logic       c_in,
    input  logic       less_in,
    output logic       r_bit,
    output logic       c_out,
    output logic       s_bit
);
    logic    a_eff;
    logic    b_eff;
    fa_out_t fa;

    always_comb begin
        a_eff = ctl.flip_a ? ~a_bit : a_bit;
        b_eff = ctl.flip_b ? ~b_bit : b_bit;
        fa    = full_add(a_eff, b_eff, c_in);
        s_bit = fa.sum;
        c_out = fa.cout;
        r_bit = pick_out(ctl.sel, a_eff & b_eff, a_eff | b_eff, fa.sum, less_in);
    end
endmodule

// File: rtl/alu_zero_tree.sv
module alu_zero_tree #(
    parameter int unsigned WIDTH = 32
) (
    input  logic [WIDTH-1:0] vec,
    output logic             all_zero
);
    localparam int unsigned HALF = WIDTH / 2;

    generate
        if (WIDTH <= 4) begin : g_leaf
            assign all_zero = ~|vec;
        end else begin : g_split
            logic lo_z;
            logic hi_z;
            alu_zero_tree #(.WIDTH(HALF)) u_lo (
                .vec      (vec[HALF-1:0]),
                .all_zero (lo_z)
            );
            alu_zero_tree #(.WIDTH(WIDTH-HALF)) u_hi (
                .vec      (vec[WIDTH-1:HALF]),
                .all_zero (hi_z)
            );
            assign all_zero = lo_z & hi_z;
        end
    endgenerate
endmodule

// File: rtl/alu32_sliced.sv
module alu32_sliced
    import alu_slice_pkg::*;
#(
    parameter int unsigned WIDTH = 32
) (
    input  logic [WIDTH-1:0] opnd_a,
    input  logic [WIDTH-1:0] opnd_b,
    input  logic             inv_a,
    input  logic             inv_b,
    input  logic [1:0]       fn_sel,
    output logic [WIDTH-1:0] result,
    output logic             zero,
    output logic             carry_out,
    output logic             overflow
);
    localparam int unsigned MSB = WIDTH - 1;

    slice_ctl_t       ctl;
    logic [WIDTH:0]   chain;
    logic [WIDTH-1:0] sums;
    logic [WIDTH-1:0] less_vec;
    logic             set_sign;

    assign ctl.flip_a = inv_a;
    assign ctl.flip_b = inv_b;
    assign ctl.sel    = fn_sel_e'(fn_sel);

    // subtract needs +1 at bit 0: invert-B doubles as the initial carry
    assign chain[0] = inv_b;

    assign overflow  = chain[MSB] ^ chain[WIDTH];
    assign carry_out = chain[WIDTH];
    // sign of the true difference, corrected when the subtraction overflows
    assign set_sign  = sums[MSB] ^ overflow;

    genvar i;
    generate
        for (i = 0; i < WIDTH; i++) begin : g_slice
            if (i == 0) begin : g_lsb_less
                assign less_vec[i] = set_sign;
            end else begin : g_tied_less
                assign less_vec[i] = 1'b0;
            end
            alu_bit_slice u_slice (
                .a_bit   (opnd_a[i]),
                .b_bit   (opnd_b[i]),
                .ctl     (ctl),
                .c_in    (chain[i]),
                .less_in (less_vec[i]),
                .r_bit   (result[i]),
                .c_out   (chain[i+1]),
                .s_bit   (sums[i])
            );
        end
    endgenerate

    alu_zero_tree #(.WIDTH(WIDTH)) u_zero (
        .vec      (result),
        .all_zero (zero)
    );
endmodule

// File: rtl/alu32_sliced_chk.sv
module alu32_sliced_chk #(
    parameter int unsigned WIDTH = 32
) (
    input logic [WIDTH-1:0] opnd_a,
    input logic [WIDTH-1:0] opnd_b,
    input logic             inv_a,
    input logic             inv_b,
    input logic [1:0]       fn_sel,
    input logic [WIDTH-1:0] result,
    input logic             zero,
    input logic             carry_out,
    input logic             overflow
);
    localparam int unsigned MSB = WIDTH - 1;

    logic             known;
    logic [WIDTH:0]   wide_sum;
    logic [WIDTH-1:0] diff;

    always @* begin
        known    = !$isunknown({opnd_a, opnd_b, inv_a, inv_b, fn_sel});
        wide_sum = {1'b0, opnd_a} + {1'b0, opnd_b};
        diff     = opnd_a - opnd_b;
        if (known) begin
            if (!inv_a && !inv_b && fn_sel == 2'd0)
                p_and_r1: assert (result == (opnd_a & opnd_b));
            if (!inv_a && !inv_b && fn_sel == 2'd2)
                p_add_carry_r3: assert ({carry_out, result} == wide_sum);
            if (!inv_a && inv_b && fn_sel == 2'd2)
                p_sub_eq_r8: assert (zero == (opnd_a == opnd_b));
            if (!inv_a && inv_b && fn_sel == 2'd2)
                p_sub_borrow_r4: assert (carry_out == (opnd_a >= opnd_b));
            if (inv_a && inv_b && fn_sel == 2'd0)
                p_nor_r5: assert (result == ~(opnd_a | opnd_b));
            if (!inv_a && inv_b && fn_sel == 2'd3)
                p_slt_r7: assert (result == {{(WIDTH-1){1'b0}}, $signed(opnd_a) < $signed(opnd_b)});
            if (!inv_a && !inv_b)
                p_add_ovf_r9: assert (overflow ==
                    ((opnd_a[MSB] == opnd_b[MSB]) && (wide_sum[MSB] != opnd_a[MSB])));
            if (!inv_a && inv_b)
                p_sub_ovf_r9: assert (overflow ==
                    ((opnd_a[MSB] != opnd_b[MSB]) && (diff[MSB] != opnd_a[MSB])));
        end
    end
endmodule

bind alu32_sliced alu32_sliced_chk #(.WIDTH(WIDTH)) u_chk (
    .opnd_a    (opnd_a),
    .opnd_b    (opnd_b),
    .inv_a     (inv_a),
    .inv_b     (inv_b),
    .fn_sel    (fn_sel),
    .result    (result),
    .zero      (zero),
    .carry_out (carry_out),
    .overflow  (overflow)
);

// File: tb/sim_alu32_sliced.sv
`timescale 1ns/1ps
module sim_alu32_sliced;
    localparam int unsigned W = 32;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] a_in = '0;
    logic [W-1:0] b_in = '0;
    logic         ia = 1'b0;
    logic         ib = 1'b0;
    logic [1:0]   fs = 2'd0;
    logic [W-1:0] res;
    logic         zf, cf, vf;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    alu32_sliced u0 (
        .opnd_a    (a_in),
        .opnd_b    (b_in),
        .inv_a     (ia),
        .inv_b     (ib),
        .fn_sel    (fs),
        .result    (res),
        .zero      (zf),
        .carry_out (cf),
        .overflow  (vf)
    );

    function automatic logic [W+2:0] model(input logic [W-1:0] a, input logic [W-1:0] b,
                                           input logic fa, input logic fb, input logic [1:0] s);
        logic [W-1:0] ea, eb, r;
        logic [W:0]   sm;
        logic         v, lt;
        ea = fa ? ~a : a;
        eb = fb ? ~b : b;
        sm = {1'b0, ea} + {1'b0, eb} + {{W{1'b0}}, fb};
        v  = (ea[W-1] == eb[W-1]) && (sm[W-1] != ea[W-1]);
        lt = sm[W-1] ^ v;
        case (s)
            2'd0: r = ea & eb;
            2'd1: r = ea | eb;
            2'd2: r = sm[W-1:0];
            default: r = {{(W-1){1'b0}}, lt};
        endcase
        return {r, (r == '0), sm[W], v};
    endfunction

    function automatic string tag_of(input logic fa, input logic fb, input logic [1:0] s);
        case (s)
            2'd0: return (fa && fb) ? "R5" : "R1";
            2'd1: return (fa && fb) ? "R6" : "R2";
            2'd2: return fa ? "R10" : (fb ? "R4" : "R3");
            default: return "R7";
        endcase
    endfunction

    task automatic apply_chk(input logic [W-1:0] a, input logic [W-1:0] b, input logic fa,
                             input logic fb, input logic [1:0] s, input string tag);
        logic [W+2:0] exp_v;
        @(negedge clk);
        a_in = a; b_in = b; ia = fa; ib = fb; fs = s;
        #5;
        exp_v = model(a, b, fa, fb, s);
        checks++;
        if ({res, zf, cf, vf} !== exp_v) begin
            fails++;
            $display("FAIL %s a=%h b=%h ia=%0b ib=%0b sel=%0d actual res=%h z=%0b c=%0b v=%0b expected res=%h z=%0b c=%0b v=%0b",
                     tag, a, b, fa, fb, s, res, zf, cf, vf,
                     exp_v[W+2:3], exp_v[2], exp_v[1], exp_v[0]);
        end
    endtask

    task automatic op_chk(input logic [W-1:0] a, input logic [W-1:0] b, input logic fa,
                          input logic fb, input logic [1:0] s);
        apply_chk(a, b, fa, fb, s, tag_of(fa, fb, s));
    endtask

    initial begin
        #(20.0 * 200000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] corner [6];
        void'($urandom(32'd20240611));
        corner[0] = 32'h0000_0000; corner[1] = 32'hFFFF_FFFF;
        corner[2] = 32'h8000_0000; corner[3] = 32'h7FFF_FFFF;
        corner[4] = 32'h0000_0001; corner[5] = 32'h0000_000B;
        repeat (3) @(posedge clk);
        rst = 1'b0;

        // idle state: all-zero inputs give zero result and flag (R8)
        apply_chk('0, '0, 1'b0, 1'b0, 2'd0, "R8");
        // R7: 10 against 11 gives 1
        apply_chk(32'd10, 32'd11, 1'b0, 1'b1, 2'd3, "R7");
        apply_chk(32'd11, 32'd10, 1'b0, 1'b1, 2'd3, "R7");
        // R7 with overflowing subtraction
        apply_chk(32'h8000_0000, 32'd1, 1'b0, 1'b1, 2'd3, "R7");
        apply_chk(32'h7FFF_FFFF, 32'hFFFF_FFFF, 1'b0, 1'b1, 2'd3, "R7");
        // R9 add and subtract overflow
        apply_chk(32'h7FFF_FFFF, 32'd1, 1'b0, 1'b0, 2'd2, "R9");
        apply_chk(32'h8000_0000, 32'd1, 1'b0, 1'b1, 2'd2, "R9");
        apply_chk(32'h8000_0000, 32'h8000_0000, 1'b0, 1'b0, 2'd2, "R9");
        // R9: flags follow the adder under a logic function
        apply_chk(32'h7FFF_FFFF, 32'd1, 1'b0, 1'b0, 2'd1, "R9");
        // R8 equality through subtract
        apply_chk(32'hDEAD_BEEF, 32'hDEAD_BEEF, 1'b0, 1'b1, 2'd2, "R8");
        apply_chk(32'hDEAD_BEEF, 32'hDEAD_BEEE, 1'b0, 1'b1, 2'd2, "R8");
        // R3 carry out of all ones plus one
        apply_chk(32'hFFFF_FFFF, 32'd1, 1'b0, 1'b0, 2'd2, "R3");
        // R10 carry-in from invert-B only
        apply_chk(32'd5, 32'd9, 1'b1, 1'b0, 2'd2, "R10");

        // corner pairs across every control pattern
        for (int i = 0; i < 6; i++)
            for (int j = 0; j < 6; j++)
                for (int c = 0; c < 16; c++)
                    op_chk(corner[i], corner[j], c[3], c[2], c[1:0]);

        // random operands, random controls
        for (int n = 0; n < 3000; n++) begin
            logic [3:0] c;
            c = 4'($urandom);
            op_chk($urandom, $urandom, c[3], c[2], c[1:0]);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule